// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Atomic Set/Clear Control

This block gathers 32 level-type interrupt lines, qualifies each one against its own trigger code, source-select bit and enable mask, and steers the survivors onto one of two request outputs. A third output flags the processor for wakeup whenever a qualified source with its wakeup bit set is active. Two copies side by side serve 64 lines: lines 0 to 31 go to the first copy and lines 32 to 63 to the second.

Software never rewrites a control register whole. Every control register has one address that ORs the written word into it and another that removes the written bits. Bits written as zero stay as they are, so separate handlers can change their own sources without a read-modify-write. A read at any of a register's addresses returns its present value. Two more read addresses return the pending sources routed to each request output.

Each trigger code is three bits, one bit in each of three control registers. Only two codes are live: `101` follows the line as active-high and `110` follows it inverted as active-low. Every other code, including `000`, keeps the source silent. Raw lines pass through one register stage before they are qualified.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control register reads zero and `irq_req0`, `irq_req1` and `wake_out` are low.
- R2: A write to address `{id,2'b01}` with id 0 to 6 ORs `bus_wdata` into control register id and leaves the bits written as zero unchanged.
- R3: A write to address `{id,2'b10}` with id 0 to 6 clears the bits of control register id that are one in `bus_wdata` and leaves the others unchanged.
- R4: The address is `{id[2:0], op[1:0]}`. Ids 0 to 6 are trigger bit 0, trigger bit 1, trigger bit 2, route, source-select, mask and wakeup-enable. A read with op 0, 1, 2 or 3 returns that register's value. Writes with op 0 or 3, and all writes to id 7, change nothing.
- R5: A source whose trigger code {bit2,bit1,bit0} is `101` is active while its sampled input is 1.
- R6: A source whose trigger code is `110` is active while its sampled input is 0.
- R7: A source whose trigger code is anything other than `101` or `110` is never active.
- R8: A source is pending only when it is active, its source-select bit is 1 and its mask bit is 1. If the mask bit is cleared and then set again while the input stays asserted, the source shows as pending again.
- R9: A pending source whose route bit is 1 appears in status word 0 (read at id 7, op 0). One whose route bit is 0 appears in status word 1 (read at id 7, op 1). Id 7 with op 2 or 3 reads zero.
- R10: `irq_req0` is high exactly when status word 0 is non-zero, and `irq_req1` exactly when status word 1 is non-zero.
- R11: `wake_out` is high exactly when some source that is active and has its source-select bit set also has its wakeup-enable bit set. The mask bit plays no part.
- R12: A source whose source-select bit is 0 is neither pending nor a wakeup cause, whatever its code and input.
- R13: Inputs are sampled on each rising clock edge. Status reads and outputs reflect the input value captured at the most recent edge, not the value on the pins now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw interrupt lines, already synchronous to clk |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 5 | Register id in bits 4:2, operation in bits 1:0 |
| bus_wdata | input | 32 | Bit mask for set or clear writes |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_req0 | output | 1 | Request line 0 |
| irq_req1 | output | 1 | Request line 1 |
| wake_out | output | 1 | Wakeup request |

## Verification
Read data is combinational from the address and current state, so the bench checks each read in the same cycle, shortly after driving the address and before the clock edge. A set or clear write takes effect at the next rising edge. An input change is captured at that same edge, so both affect the outputs and status from the following cycle on. The bench therefore updates its reference model at each rising edge and compares `irq_req0`, `irq_req1` and `wake_out` one time step after that edge. A status read made in the same cycle as an input change must still show the previously captured value, and the R13 check is built on that.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Address layout: {register id, operation}
    localparam int ID_W   = 3;
    localparam int OP_W   = 2;
    localparam int ADDR_W = ID_W + OP_W;

    // Control register ids
    localparam logic [ID_W-1:0] RID_TRIG0  = 3'd0;
    localparam logic [ID_W-1:0] RID_TRIG1  = 3'd1;
    localparam logic [ID_W-1:0] RID_TRIG2  = 3'd2;
    localparam logic [ID_W-1:0] RID_ROUTE  = 3'd3;
    localparam logic [ID_W-1:0] RID_SRCSEL = 3'd4;
    localparam logic [ID_W-1:0] RID_MASK   = 3'd5;
    localparam logic [ID_W-1:0] RID_WAKE   = 3'd6;
    localparam logic [ID_W-1:0] RID_STAT   = 3'd7;

    localparam int NUM_CTRL = 7;

    // Operations
    localparam logic [OP_W-1:0] OP_VIEW = 2'd0;
    localparam logic [OP_W-1:0] OP_SET  = 2'd1;
    localparam logic [OP_W-1:0] OP_CLR  = 2'd2;
    localparam logic [OP_W-1:0] OP_RSVD = 2'd3;

    // Live trigger codes {bit2, bit1, bit0}
    localparam logic [2:0] TRIG_LVL_HI = 3'b101;
    localparam logic [2:0] TRIG_LVL_LO = 3'b110;

endpackage

// File: rtl/irqc_regbank.sv
module irqc_regbank
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ID_W-1:0]                   wr_id,
    input  logic [OP_W-1:0]                   wr_op,
    input  logic [N_SRC-1:0]                  wr_mask,
    output logic [NUM_CTRL-1:0][N_SRC-1:0]    ctrl_q
);

    typedef struct packed {
        logic [NUM_CTRL-1:0][N_SRC-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int r = 0; r < NUM_CTRL; r++) begin
                if (wr_id == ID_W'(r)) begin
                    if (wr_op == OP_SET) begin
                        bank_d.regs[r] = bank_q.regs[r] | wr_mask;
                    end else if (wr_op == OP_CLR) begin
                        bank_d.regs[r] = bank_q.regs[r] & ~wr_mask;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign ctrl_q = bank_q.regs;

endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_raw,
    input  logic [N_SRC-1:0] trig0,
    input  logic [N_SRC-1:0] trig1,
    input  logic [N_SRC-1:0] trig2,
    input  logic [N_SRC-1:0] route,
    input  logic [N_SRC-1:0] srcsel,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] wake_en,
    output logic [N_SRC-1:0] stat0,
    output logic [N_SRC-1:0] stat1,
    output logic [N_SRC-1:0] wake_hits
);

    typedef struct packed {
        logic [N_SRC-1:0] smp;
    } samp_t;

    samp_t samp_d, samp_q;
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] qual;
    logic [N_SRC-1:0] pend;

    always_comb begin
        samp_d     = samp_q;
        samp_d.smp = src_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    // Per-source trigger decode
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [2:0] code;
        assign code = {trig2[i], trig1[i], trig0[i]};
        always_comb begin
            if (code == TRIG_LVL_HI) begin
                live[i] = samp_q.smp[i];
            end else if (code == TRIG_LVL_LO) begin
                live[i] = ~samp_q.smp[i];
            end else begin
                live[i] = 1'b0;
            end
        end
    end

    assign qual      = live & srcsel;
    assign pend      = qual & mask;
    assign stat0     = pend & route;
    assign stat1     = pend & ~route;
    assign wake_hits = qual & wake_en;

endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic [ID_W-1:0]                rd_id,
    input  logic [OP_W-1:0]                rd_op,
    input  logic [NUM_CTRL-1:0][N_SRC-1:0] ctrl_q,
    input  logic [N_SRC-1:0]               stat0,
    input  logic [N_SRC-1:0]               stat1,
    output logic [N_SRC-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        if (rd_id == RID_STAT) begin
            if (rd_op == OP_VIEW) begin
                rdata = stat0;
            end else if (rd_op == OP_SET) begin
                rdata = stat1;
            end
        end else begin
            for (int r = 0; r < NUM_CTRL; r++) begin
                if (rd_id == ID_W'(r)) begin
                    rdata = ctrl_q[r];
                end
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_req0,
    output logic              irq_req1,
    output logic              wake_out
);

    logic [ID_W-1:0]                acc_id;
    logic [OP_W-1:0]                acc_op;
    logic [NUM_CTRL-1:0][N_SRC-1:0] ctrl_q;
    logic [N_SRC-1:0]               stat0;
    logic [N_SRC-1:0]               stat1;
    logic [N_SRC-1:0]               wake_hits;

    assign acc_id = bus_addr[ADDR_W-1:OP_W];
    assign acc_op = bus_addr[OP_W-1:0];

    irqc_regbank #(.N_SRC(N_SRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_en & bus_we),
        .wr_id   (acc_id),
        .wr_op   (acc_op),
        .wr_mask (bus_wdata),
        .ctrl_q  (ctrl_q)
    );

    irqc_qualify #(.N_SRC(N_SRC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_raw   (irq_src),
        .trig0     (ctrl_q[RID_TRIG0]),
        .trig1     (ctrl_q[RID_TRIG1]),
        .trig2     (ctrl_q[RID_TRIG2]),
        .route     (ctrl_q[RID_ROUTE]),
        .srcsel    (ctrl_q[RID_SRCSEL]),
        .mask      (ctrl_q[RID_MASK]),
        .wake_en   (ctrl_q[RID_WAKE]),
        .stat0     (stat0),
        .stat1     (stat1),
        .wake_hits (wake_hits)
    );

    irqc_readmux #(.N_SRC(N_SRC)) u_rmux (
        .rd_id  (acc_id),
        .rd_op  (acc_op),
        .ctrl_q (ctrl_q),
        .stat0  (stat0),
        .stat1  (stat1),
        .rdata  (bus_rdata)
    );

    assign irq_req0 = |stat0;
    assign irq_req1 = |stat1;
    assign wake_out = |wake_hits;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_en,
    input logic                           bus_we,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [N_SRC-1:0]               bus_wdata,
    input logic                           irq_req0,
    input logic                           irq_req1,
    input logic                           wake_out,
    input logic [NUM_CTRL-1:0][N_SRC-1:0] ctrl_q,
    input logic [N_SRC-1:0]               stat0,
    input logic [N_SRC-1:0]               stat1
);

    logic set_wr;
    logic clr_wr;
    assign set_wr = bus_en && bus_we && (bus_addr[OP_W-1:0] == OP_SET)
                    && (bus_addr[ADDR_W-1:OP_W] != RID_STAT);
    assign clr_wr = bus_en && bus_we && (bus_addr[OP_W-1:0] == OP_CLR)
                    && (bus_addr[ADDR_W-1:OP_W] != RID_STAT);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0));

    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((ctrl_q[$past(bus_addr[ADDR_W-1:OP_W])] & $past(bus_wdata))
                    == $past(bus_wdata)));

    p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ctrl_q[$past(bus_addr[ADDR_W-1:OP_W])] & $past(bus_wdata)) == '0));

    p_dead_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 | stat1) & ~ctrl_q[RID_TRIG2]) == '0);

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 | stat1) & ~ctrl_q[RID_MASK]) == '0);

    p_route_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 & ~ctrl_q[RID_ROUTE]) | (stat1 & ctrl_q[RID_ROUTE])) == '0);

    p_req0_needs_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req0 |-> |(ctrl_q[RID_MASK] & ctrl_q[RID_ROUTE]));

    p_req1_needs_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req1 |-> |(ctrl_q[RID_MASK] & ~ctrl_q[RID_ROUTE]));

    p_wake_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_out |-> |(ctrl_q[RID_WAKE] & ctrl_q[RID_SRCSEL]));

    p_srcsel_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 | stat1) & ~ctrl_q[RID_SRCSEL]) == '0);

endmodule

bind irq_ctrl irqc_checker #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req0, irq_req1, wake_out;

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [31:0] m [7];
    logic [31:0] ms;
    logic [31:0] cur_src;

    always #5 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
    );

    function automatic logic [31:0] live_f();
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++) begin
            logic [2:0] c = {m[2][i], m[1][i], m[0][i]};
            if (c == 3'b101) v[i] = ms[i];
            else if (c == 3'b110) v[i] = ~ms[i];
        end
        return v & m[4];
    endfunction

    function automatic logic [31:0] st_f(input int which);
        logic [31:0] p = live_f() & m[5];
        return (which == 0) ? (p & m[3]) : (p & ~m[3]);
    endfunction

    function automatic logic [31:0] read_f(input int id, input int op);
        if (id == 7) begin
            if (op == 0) return st_f(0);
            if (op == 1) return st_f(1);
            return '0;
        end
        return m[id];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit en, input bit we, input int id, input int op,
                        input logic [31:0] d, input logic [31:0] src, input string tag);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = {3'(id), 2'(op)};
        bus_wdata = d; irq_src = src; cur_src = src;
        #1;
        if (en && !we) chk(tag, bus_rdata, read_f(id, op));
        @(posedge clk);
        if (en && we && id < 7) begin
            if (op == 1) m[id] = m[id] | d;
            else if (op == 2) m[id] = m[id] & ~d;
        end
        ms = src;
        #1;
        chk("R10 req0", 32'(irq_req0), 32'(|st_f(0)));
        chk("R10 req1", 32'(irq_req1), 32'(|st_f(1)));
        chk("R11 wake", 32'(wake_out), 32'(|(live_f() & m[6])));
        bus_en = 1'b0;
    endtask

    task automatic wr(input int id, input int op, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, id, op, d, cur_src, tag);
    endtask

    task automatic rd(input int id, input int op, input string tag);
        step(1'b1, 1'b0, id, op, '0, cur_src, tag);
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 7; r++) m[r] = '0;
        ms = '0; cur_src = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 7; r++) rd(r, 0, "R1");
        chk("R1 req0", 32'(irq_req0), 0);
        chk("R1 wake", 32'(wake_out), 0);

        // R2 / R4: set is OR, read at set address
        wr(5, 1, 32'h0000_00F0, "R2");
        wr(5, 1, 32'h0000_000F, "R2");
        rd(5, 1, "R2 R4");
        // R4: view/reserved op writes ignored
        wr(5, 0, 32'hFFFF_0000, "R4");
        wr(5, 3, 32'hFFFF_0000, "R4");
        wr(7, 1, 32'hFFFF_FFFF, "R4");
        rd(5, 3, "R4");
        // R3: clear
        wr(5, 2, 32'h0000_003C, "R3");
        rd(5, 2, "R3");

        // R5: source 0 active-high, route 1 -> status 0
        wr(2, 1, 32'h1, "R5"); wr(0, 1, 32'h1, "R5");
        wr(4, 1, 32'h1, "R5"); wr(3, 1, 32'h1, "R5");
        step(1'b0, 1'b0, 0, 0, '0, 32'h1, "R5");
        rd(7, 0, "R5 R9");

        // R6: source 1 active-low, route 0 -> status 1, input low
        wr(2, 1, 32'h2, "R6"); wr(1, 1, 32'h2, "R6"); wr(4, 1, 32'h2, "R6");
        rd(7, 1, "R6 R9");
        rd(7, 2, "R9");

        // R7: source 6 with code 111 stays silent
        wr(0, 1, 32'h40, "R7"); wr(1, 1, 32'h40, "R7"); wr(2, 1, 32'h40, "R7");
        wr(4, 1, 32'h40, "R7");
        step(1'b0, 1'b0, 0, 0, '0, 32'h41, "R7");
        rd(7, 0, "R7"); rd(7, 1, "R7");

        // R8: mask toggle with input held
        wr(5, 2, 32'h1, "R8");
        rd(7, 0, "R8");
        wr(5, 1, 32'h1, "R8");
        rd(7, 0, "R8");

        // R11: wakeup on masked-off source 1
        wr(5, 2, 32'h2, "R11");
        wr(6, 1, 32'h2, "R11");
        chk("R11 wake on", 32'(wake_out), 32'h1);

        // R12: source-select off kills source 0
        wr(4, 2, 32'h1, "R12");
        rd(7, 0, "R12");
        wr(4, 1, 32'h1, "R12");

        // R13: read in the cycle the input drops still shows old sample
        step(1'b1, 1'b0, 7, 0, '0, 32'h40, "R13");
        rd(7, 0, "R13");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int id = $urandom_range(0, 7);
            int op = $urandom_range(0, 3);
            logic [31:0] d = $urandom();
            logic [31:0] s = ($urandom_range(0, 3) == 0) ? $urandom() : cur_src;
            bit we = $urandom_range(0, 1);
            bit en = ($urandom_range(0, 9) != 0);
            step(en, we, id, op, d, s, (id == 7) ? "R9" : "R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule